// File: doc/BRIEF.md
# Memory Parity Error Latch

This block captures the result of a memory parity check at the correct point of each memory cycle and holds it as a sticky error. Two sampling flops watch the parity-good line. The slow-path flop samples at the start of the first timing pulse and the fast-path flop samples at its end. The memory-direction level chooses which of the two may pass a failure on. While the direction level is high the cycle is fast, and only the fast path is passed. Once the direction level has dropped the cycle is slow, and only the slow path is passed. The passed result is the pending error. It raises an interrupt request at once when interrupts are enabled, and it is loaded into the error flop at the end of the second timing pulse.

Timing edges arrive as single-clock strobes on a common clock. Each flop changes only on its own strobe, on the synchronous reset, or on the functional initialize input. Once the error is latched, both sampling flops load a failure on every later sample. The error therefore stays set until a clear command is seen at the start of the second timing pulse. That command empties both sampling flops, and the error flop then loads a zero at the end of the pulse.

Top module: `pel_top`

## Requirements
- R1: While `rst_n` is low or `init` is high at a clock edge, all three flops clear, and `err_flag`, `err_pend` and `irq_req` read 0 after that edge.
- R2: With `mem_out` = 1 (fast cycle), a `tp2_trail` strobe with `parity_ok` = 0 makes `err_pend` 1 after that edge.
- R3: With `mem_out` = 0 (slow cycle), the result taken at the `tp2_lead` strobe drives `err_pend`. A failure seen only at `tp2_trail` on a slow cycle does not raise `err_pend`.
- R4: A failure seen only at `tp2_lead` while `mem_out` stays 1 does not raise `err_pend`.
- R5: `irq_req` equals `err_pend` AND `irq_en`, with no clock delay.
- R6: `err_flag` changes only on a `tp3_trail` strobe, where it loads `err_pend`, or on reset or initialize.
- R7: Once `err_flag` is 1, later samples with `parity_ok` = 1 leave `err_flag` and `err_pend` at 1.
- R8: `clr_err` high at a `tp3_lead` strobe clears both sampling flops, so `err_pend` is 0 after that edge. `err_flag` is 0 after the next `tp3_trail` strobe. `clr_err` at any other time has no effect.
- R9: Changes on `parity_ok` between strobes have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst_n | input | 1 | Synchronous active-low reset |
| parity_ok | input | 1 | High when the word read has odd parity |
| mem_out | input | 1 | Direction level: 1 selects the fast path, 0 the slow path |
| tp2_lead | input | 1 | One-clock strobe, start of first timing pulse |
| tp2_trail | input | 1 | One-clock strobe, end of first timing pulse |
| tp3_lead | input | 1 | One-clock strobe, start of second timing pulse |
| tp3_trail | input | 1 | One-clock strobe, end of second timing pulse |
| clr_err | input | 1 | Clear command, taken at `tp3_lead` |
| irq_en | input | 1 | Interrupt enable level |
| init | input | 1 | Functional initialize, clears all flops |
| err_flag | output | 1 | Sticky error, also used as the skip condition |
| err_pend | output | 1 | Steered sample result that feeds the error flop |
| irq_req | output | 1 | Interrupt request |

## Verification
A wrong sampling flop shows at `err_pend` and `irq_req` in the clock after the strobe that loaded it, but only while `mem_out` selects that path. A slow-path fault can therefore stay hidden until a slow cycle follows. A wrong error flop shows at `err_flag` after the next `tp3_trail`. If the hold-high term fails, a latched error decays within one memory cycle of good parity. A broken clear leaves `err_flag` set past the `tp3_trail` that follows the command.

// File: rtl/pel_pkg.sv
// Shared constants for the parity error latch.
// Assumes two capture paths: index 0 is the fast path, index 1 the slow path.
package pel_pkg;
    localparam int NUM_PATHS = 2;
    localparam int PATH_FAST = 0;
    localparam int PATH_SLOW = 1;
endpackage

// File: rtl/pel_sample_ff.sv
// One capture path: samples a parity failure on its strobe and passes it on
// only while the direction level matches STEER_LEVEL.
// Assumes strobes are single-clock pulses; clear outranks sample.
module pel_sample_ff #(
    parameter bit STEER_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic init,
    input  logic sample,
    input  logic clear,
    input  logic fail_in,
    input  logic hold_in,
    input  logic mem_out,
    output logic q,
    output logic pass
);
    // Capture flop: reset/init, then clear, then sample, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n || init)
            q <= 1'b0;
        else if (clear)
            q <= 1'b0;
        else if (sample)
            q <= fail_in | hold_in;
    end

    // Steering gate: path result counts only in its own cycle type.
    always_comb pass = q & (mem_out == STEER_LEVEL);
endmodule

// File: rtl/pel_error_ff.sv
// Sticky error flop: loads the pending error on the end-of-pulse strobe.
// Assumes the strobe is a single-clock pulse.
module pel_error_ff (
    input  logic clk,
    input  logic rst_n,
    input  logic init,
    input  logic load,
    input  logic d,
    output logic q
);
    // Error register: reset/init clears, strobe loads.
    always_ff @(posedge clk) begin
        if (!rst_n || init)
            q <= 1'b0;
        else if (load)
            q <= d;
    end
endmodule

// File: rtl/pel_top.sv
// Parity error latch top: two steered capture paths, one sticky error flop,
// and interrupt gating. Assumes all timing edges are one-clock strobes.
module pel_top (
    input  logic clk,
    input  logic rst_n,
    input  logic parity_ok,
    input  logic mem_out,
    input  logic tp2_lead,
    input  logic tp2_trail,
    input  logic tp3_lead,
    input  logic tp3_trail,
    input  logic clr_err,
    input  logic irq_en,
    input  logic init,
    output logic err_flag,
    output logic err_pend,
    output logic irq_req
);
    import pel_pkg::*;

    logic [NUM_PATHS-1:0] path_q;
    logic [NUM_PATHS-1:0] path_pass;
    logic                 path_clear;
    logic                 fail_now;

    // Clear command acts only at the start of the second pulse.
    always_comb path_clear = tp3_lead & clr_err;
    // Failure seen on the parity line this clock.
    always_comb fail_now = ~parity_ok;

    for (genvar i = 0; i < NUM_PATHS; i++) begin : g_path
        localparam bit IS_FAST = (i == PATH_FAST);
        pel_sample_ff #(.STEER_LEVEL(IS_FAST)) u_path (
            .clk     (clk),
            .rst_n   (rst_n),
            .init    (init),
            .sample  (IS_FAST ? tp2_trail : tp2_lead),
            .clear   (path_clear),
            .fail_in (fail_now),
            .hold_in (err_flag),
            .mem_out (mem_out),
            .q       (path_q[i]),
            .pass    (path_pass[i])
        );
    end

    // Pending error: any steered path reporting a failure.
    always_comb err_pend = |path_pass;

    pel_error_ff u_err (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (init),
        .load  (tp3_trail),
        .d     (err_pend),
        .q     (err_flag)
    );

    // Interrupt gating: request follows the pending error when enabled.
    always_comb irq_req = err_pend & irq_en;
endmodule

// File: rtl/pel_checker.sv
// Timing checks for the parity error latch, bound onto pel_top.
module pel_checker (
    input logic clk,
    input logic rst_n,
    input logic init,
    input logic tp2_lead,
    input logic tp2_trail,
    input logic tp3_lead,
    input logic tp3_trail,
    input logic clr_err,
    input logic irq_en,
    input logic fast_q,
    input logic slow_q,
    input logic err_pend,
    input logic err_flag,
    input logic irq_req
);
    a_r1_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> (!err_flag && !fast_q && !slow_q));
    a_r5_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq_req);
    a_r6_err_only_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (!tp3_trail && !init) |=> $stable(err_flag));
    a_r6_err_loads_pend: assert property (@(posedge clk) disable iff (!rst_n)
        (tp3_trail && !init) |=> (err_flag == $past(err_pend)));
    a_r7_fast_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && tp2_trail && !init && !(tp3_lead && clr_err)) |=> fast_q);
    a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (tp3_lead && clr_err) |=> (!fast_q && !slow_q));
    a_r9_slow_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!tp2_lead && !tp3_lead && !init) |=> $stable(slow_q));
endmodule

bind pel_top pel_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .init      (init),
    .tp2_lead  (tp2_lead),
    .tp2_trail (tp2_trail),
    .tp3_lead  (tp3_lead),
    .tp3_trail (tp3_trail),
    .clr_err   (clr_err),
    .irq_en    (irq_en),
    .fast_q    (path_q[0]),
    .slow_q    (path_q[1]),
    .err_pend  (err_pend),
    .err_flag  (err_flag),
    .irq_req   (irq_req)
);

// File: tb/pel_top_tb.sv
// Bench for pel_top: directed corners plus seeded random memory cycles,
// checked against a reference model of the requirements.
module pel_top_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n, parity_ok, mem_out, tp2_lead, tp2_trail, tp3_lead, tp3_trail;
    logic clr_err, irq_en, init;
    logic err_flag, err_pend, irq_req;

    int n_checks = 0;
    int n_errors = 0;
    bit m_f, m_s, m_e;

    always #(CLK_PERIOD/2) clk = ~clk;

    pel_top u_dut (.*);

    function automatic bit model_pend(bit f, bit s, bit dir);
        return (f & dir) | (s & ~dir);
    endfunction

    task automatic check(string req, string what, bit act, bit exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic check_all(string req);
        bit p;
        p = model_pend(m_f, m_s, mem_out);
        check(req, "err_pend", err_pend, p);
        check(req, "irq_req", irq_req, p & irq_en);
        check(req, "err_flag", err_flag, m_e);
    endtask

    // Drive one clock with the given strobe (0 none,1 tp2l,2 tp2t,3 tp3l,4 tp3t).
    task automatic step(int which, string req);
        tp2_lead  = (which == 1);
        tp2_trail = (which == 2);
        tp3_lead  = (which == 3);
        tp3_trail = (which == 4);
        @(negedge clk);
        case (which)
            1: m_s = ~parity_ok | m_e;
            2: m_f = ~parity_ok | m_e;
            3: if (clr_err) begin m_f = 0; m_s = 0; end
            4: m_e = model_pend(m_f, m_s, mem_out);
            default: ;
        endcase
        tp2_lead = 0; tp2_trail = 0; tp3_lead = 0; tp3_trail = 0;
        check_all(req);
    endtask

    // One memory cycle: fast keeps mem_out high; slow drops it after tp2_lead.
    task automatic mem_cycle(bit fast, bit ok_lead, bit ok_trail, bit clr, string req);
        mem_out = 1; parity_ok = 1; clr_err = 0;
        step(0, req);
        parity_ok = ok_lead;
        step(1, req);
        if (!fast) mem_out = 0;
        parity_ok = ok_trail;
        step(2, req);
        parity_ok = 1;
        step(0, req);
        clr_err = clr;
        step(3, req);
        clr_err = 0;
        step(4, req);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_errors++; n_checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        rst_n = 0; init = 0; parity_ok = 0; mem_out = 1; irq_en = 1; clr_err = 0;
        tp2_lead = 0; tp2_trail = 0; tp3_lead = 0; tp3_trail = 0;
        m_f = 0; m_s = 0; m_e = 0;
        repeat (3) @(negedge clk);
        check_all("R1");
        rst_n = 1;

        // R2: fast cycle failure at trailing edge
        mem_cycle(1, 1, 0, 0, "R2");
        check("R2", "err_flag set", err_flag, 1'b1);
        // R7: sticky across good cycles of both kinds
        mem_cycle(1, 1, 1, 0, "R7");
        mem_cycle(0, 1, 1, 0, "R7");
        check("R7", "err_flag held", err_flag, 1'b1);
        // R9: parity toggling with no strobe
        parity_ok = 0; step(0, "R9"); parity_ok = 1; step(0, "R9");
        // R8: clear outside tp3_lead has no effect, then real clear
        clr_err = 1; step(0, "R8"); step(4, "R8"); clr_err = 0;
        check("R8", "clr ignored off-strobe", err_flag, 1'b1);
        mem_cycle(1, 1, 1, 1, "R8");
        check("R8", "err_flag cleared", err_flag, 1'b0);
        // R3: slow cycle failure at leading edge; trailing-only ignored
        mem_cycle(0, 1, 0, 0, "R3");
        check("R3", "trail ignored on slow", err_flag, 1'b0);
        mem_cycle(0, 0, 1, 0, "R3");
        check("R3", "slow failure latched", err_flag, 1'b1);
        mem_cycle(1, 1, 1, 1, "R8");
        // R4: lead-only failure on fast cycle ignored
        mem_cycle(1, 0, 1, 0, "R4");
        check("R4", "lead ignored on fast", err_flag, 1'b0);
        // R5: interrupt masked
        irq_en = 0;
        mem_cycle(1, 1, 0, 0, "R5");
        irq_en = 1; #1;
        check("R5", "irq after enable", irq_req, err_pend);
        // R1: initialize clears latched error
        init = 1; @(negedge clk); init = 0;
        m_f = 0; m_s = 0; m_e = 0;
        check_all("R1");

        // Random cycles with a fixed seed
        void'($urandom(32'd1234));
        for (int k = 0; k < 300; k++) begin
            irq_en = $urandom_range(1, 0);
            mem_cycle($urandom_range(1, 0), ($urandom_range(3, 0) != 0),
                      ($urandom_range(3, 0) != 0), ($urandom_range(3, 0) == 0), "R6");
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule